// File: doc/BRIEF.md
# Row-Column Bit Interleaver Address Generator

This block produces the read addresses for a rectangular bit interleaver placed after a block code. A sequence of E bits is pictured as a matrix with Qm rows and E/Qm columns, filled row by row and emptied column by column. After one start strobe the block emits one buffer address per cycle. A downstream buffer RAM uses these addresses to read the coded bits in interleaved order. The same logic emits the inverse order when the deinterleave mode bit is set.

The column count E/Qm is worked out once per run by a small serial divider. Each address then comes from a single add-and-select step. At the first element of a pass the address restarts at the outer index. At every other element the previous address is increased by a fixed stride. Deinterleaving swaps the stride and the two loop bounds, so no second datapath is needed.

Top module: `rcil_addr_gen`

## Requirements
- R1: After reset, and until a start is accepted, valid_o and last_o are low.
- R2: A start is accepted only in idle, only when qm_i is one of 1, 2, 4, 6 or 8, and only when len_i is nonzero. A start with any other qm_i value, or with len_i equal to zero, produces no valid cycle.
- R3: In interleave mode (deint_i = 0), with C = E/Qm, the address at output position k = j*Qm + i is j + i*C. Here i runs from 0 to Qm-1 in the inner loop and j runs from 0 to C-1 in the outer loop. Every address is below E.
- R4: In deinterleave mode (deint_i = 1), the address at output position p = i*C + j is j*Qm + i. Here j runs from 0 to C-1 in the inner loop and i runs from 0 to Qm-1 in the outer loop. Applying this order to the interleaved stream restores the original order.
- R5: Each accepted run asserts valid_o for exactly E consecutive cycles. The first valid cycle comes no more than LEN_W+4 cycles after the clock edge that accepted the start.
- R6: last_o is high on the final valid cycle of a run and on no other cycle.
- R7: A start that arrives while a run is in progress changes neither the configuration nor the address sequence, and it never launches a further run.
- R8: Once last_o has been given, the block returns to idle and accepts the next start. Back-to-back runs with different settings each follow R3 or R4.
- R9: Degenerate shapes work: Qm = 1, and E = Qm (a single column), each yield the addresses 0 to E-1 in order in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled in idle |
| len_i | input | LEN_W | Sequence length E, a multiple of qm_i |
| qm_i | input | QM_W | Modulation order (row count) |
| deint_i | input | 1 | 0 = interleave order, 1 = deinterleave order |
| addr_o | output | LEN_W | Buffer address for the current output position |
| valid_o | output | 1 | addr_o is meaningful this cycle |
| last_o | output | 1 | Final address of the run |

## Verification
The bench builds the block with LEN_W = 10. This keeps the divider latency at ten cycles and caps E at 1023, so a run at the largest length and order (E = 1016 with Qm = 8, 127 columns) finishes quickly. The bench also covers every legal order, the single-column and single-row shapes, a start poked in mid-run, and illegal orders. With the narrow width, the counters and the stride adder reach their upper bits within a short bench.

// File: rtl/rcil_pkg.sv
package rcil_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_RUN  = 2'd2
  } rcil_state_e;

  // Row counts the interleaver supports.
  function automatic logic qm_ok(input int unsigned q);
    return (q == 1) || (q == 2) || (q == 4) || (q == 6) || (q == 8);
  endfunction

endpackage

// File: rtl/rcil_coldiv.sv
// Serial restoring divider: one quotient bit per cycle, W cycles per run.
module rcil_coldiv #(
  parameter int W  = 14,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [W-1:0]  quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_n;
  logic [DW-1:0] rem_q, rem_n;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          done_q, done_n;
  logic [DW:0]   trial;
  logic          ge;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    ge     = (trial >= {1'b0, den_q});
    quo_n  = quo_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    done_n = 1'b0;
    if (load_i) begin
      quo_n = num_i;
      rem_n = '0;
      cnt_n = CW'(W);
      act_n = 1'b1;
    end else if (act_q) begin
      quo_n = {quo_q[W-2:0], ge};
      rem_n = ge ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        act_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      den_q <= '0;
    else if (load_i) den_q <= den_i;
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !act_q) else $error("divider done while active"); // R5
endmodule

// File: rtl/rcil_walker.sv
// Add-and-select address recursion over an inner and an outer loop.
module rcil_walker #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] stride_i,
  input  logic [W-1:0] inner_lim_i,
  input  logic [W-1:0] outer_lim_i,
  output logic [W-1:0] addr_o,
  output logic         valid_o,
  output logic         last_o
);
  logic [W-1:0] stride_q, ilim_q, olim_q;
  logic [W-1:0] addr_q, addr_n;
  logic [W-1:0] inner_q, inner_n;
  logic [W-1:0] outer_q, outer_n;
  logic         valid_q, valid_n;
  logic         inner_end, outer_end;

  assign inner_end = (inner_q == ilim_q);
  assign outer_end = (outer_q == olim_q);

  always_comb begin
    addr_n  = addr_q;
    inner_n = inner_q;
    outer_n = outer_q;
    valid_n = valid_q;
    if (go_i) begin
      addr_n  = '0;
      inner_n = '0;
      outer_n = '0;
      valid_n = 1'b1;
    end else if (valid_q) begin
      if (!inner_end) begin
        inner_n = inner_q + 1'b1;
        addr_n  = addr_q + stride_q;
      end else if (!outer_end) begin
        inner_n = '0;
        outer_n = outer_q + 1'b1;
        addr_n  = outer_q + 1'b1;
      end else begin
        valid_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      inner_q <= '0;
      outer_q <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_n;
      inner_q <= inner_n;
      outer_q <= outer_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      ilim_q   <= '0;
      olim_q   <= '0;
    end else if (go_i) begin
      stride_q <= stride_i;
      ilim_q   <= inner_lim_i;
      olim_q   <= outer_lim_i;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;
  assign last_o  = valid_q & inner_end & outer_end;

  AST_WALK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (inner_q <= ilim_q) && (outer_q <= olim_q)) else $error("loop index out of bounds"); // R5
  AST_PASS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && inner_q == '0) |-> (addr_q == outer_q)) else $error("pass start address wrong"); // R3
endmodule

// File: rtl/rcil_addr_gen.sv
module rcil_addr_gen #(
  parameter int LEN_W = 14,
  parameter int QM_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [QM_W-1:0]  qm_i,
  input  logic             deint_i,
  output logic [LEN_W-1:0] addr_o,
  output logic             valid_o,
  output logic             last_o
);
  import rcil_pkg::*;
  localparam int PW = LEN_W + QM_W;

  rcil_state_e      state_q, state_n;
  logic [LEN_W-1:0] len_q;
  logic [QM_W-1:0]  qm_q;
  logic             mode_q;
  logic             qm_legal, accept;
  logic             div_done;
  logic [LEN_W-1:0] quo;
  logic [LEN_W-1:0] qm_w;
  logic [LEN_W-1:0] stride, ilim, olim;

  assign qm_legal = qm_ok(32'(qm_i));
  assign accept   = (state_q == ST_IDLE) && start_i && qm_legal && (len_i != '0);
  assign qm_w     = {{(LEN_W-QM_W){1'b0}}, qm_q};

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)             state_n = ST_DIV;
      ST_DIV:  if (div_done)           state_n = ST_RUN;
      ST_RUN:  if (valid_o && last_o)  state_n = ST_IDLE;
      default:                         state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      qm_q   <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      len_q  <= len_i;
      qm_q   <= qm_i;
      mode_q <= deint_i;
    end
  end

  rcil_coldiv #(.W(LEN_W), .DW(QM_W)) div_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .num_i  (len_i),
    .den_i  (qm_i),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_comb begin
    if (mode_q) begin
      stride = qm_w;
      ilim   = quo - 1'b1;
      olim   = qm_w - 1'b1;
    end else begin
      stride = quo;
      ilim   = qm_w - 1'b1;
      olim   = quo - 1'b1;
    end
  end

  rcil_walker #(.W(LEN_W)) walk_u (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (div_done),
    .stride_i    (stride),
    .inner_lim_i (ilim),
    .outer_lim_i (olim),
    .addr_o      (addr_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o) else $error("last without valid"); // R6
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (addr_o < len_q)) else $error("address beyond length"); // R3
  AST_RUN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o) |=> !valid_o) else $error("valid after last"); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(len_q) && $stable(qm_q) && $stable(mode_q))) else $error("config changed mid run"); // R7
  AST_BAD_QM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && !qm_legal) |=> (state_q == ST_IDLE)) else $error("illegal order accepted"); // R2
  AST_COLS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (PW'(quo) * PW'(qm_q) == PW'(len_q))) else $error("column count wrong"); // R3
  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (state_q == ST_RUN)) else $error("valid outside run"); // R1
endmodule

// File: tb/rcil_addr_gen_tb.sv
module rcil_addr_gen_tb_top;
  localparam int LW = 10;
  localparam int QW = 4;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [LW-1:0] len_i;
  logic [QW-1:0] qm_i;
  logic          deint_i;
  logic [LW-1:0] addr_o;
  logic          valid_o;
  logic          last_o;

  int checks = 0;
  int errors = 0;
  int cap  [0:1023];
  int ilv  [0:1023];
  int ncap;

  rcil_addr_gen #(.LEN_W(LW), .QM_W(QW)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .len_i   (len_i),
    .qm_i    (qm_i),
    .deint_i (deint_i),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  // Start one run and capture it; optionally poke a second start mid-run.
  task automatic run_seq(input int e, input int q, input bit de, input bit poke, input string req);
    int first = -1;
    int lastcnt = 0;
    int lastpos = -1;
    bit gap = 0;
    bit prev = 0;
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(e); qm_i = QW'(q); deint_i = de;
    @(negedge clk);
    start_i = 1'b0;
    ncap = 0;
    for (int c = 0; c < e + LW + 24; c++) begin
      if (valid_o) begin
        if (first < 0) first = c;
        else if (!prev) gap = 1;
        cap[ncap] = int'(addr_o);
        if (last_o) begin lastcnt++; lastpos = ncap; end
        ncap++;
      end
      prev = valid_o;
      if (poke && ncap == 2) begin
        start_i = 1'b1; len_i = LW'(8); qm_i = QW'(2); deint_i = ~de;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(ncap == e, {req, " R5 valid count"}, ncap, e);
    chk(!gap, {req, " R5 contiguous valid"}, int'(gap), 0);
    chk(first >= 0 && first <= LW + 4, {req, " R5 first valid latency"}, first, LW + 4);
    chk(lastcnt == 1 && lastpos == e - 1, {req, " R6 last position"}, lastpos, e - 1);
    chk(!valid_o, {req, " R7 no further run"}, int'(valid_o), 0);
    for (int k = 0; k < e; k++) begin
      int c = e / q;
      int ex;
      if (!de) ex = (k / q) + (k % q) * c;
      else     ex = (k % c) * q + (k / c);
      chk(cap[k] == ex, {req, de ? " R4 deinterleave address" : " R3 interleave address"}, cap[k], ex);
    end
  endtask

  task automatic t_reset();
    start_i = 1'b0; len_i = '0; qm_i = '0; deint_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!valid_o, "R1 valid after reset", int'(valid_o), 0);
    chk(!last_o, "R1 last after reset", int'(last_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!valid_o, "R1 valid idle", int'(valid_o), 0);
  endtask

  task automatic t_illegal();
    int seen = 0;
    int bad [4] = '{3, 5, 0, 9};
    foreach (bad[n]) begin
      @(negedge clk);
      start_i = 1'b1; len_i = LW'(24); qm_i = QW'(bad[n]); deint_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < LW + 40; c++) begin
        if (valid_o) seen++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    start_i = 1'b1; len_i = '0; qm_i = QW'(4);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < LW + 40; c++) begin
      if (valid_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R2 illegal start ignored", seen, 0);
  endtask

  task automatic t_inverse(input int e, input int q);
    int c = e / q;
    run_seq(e, q, 1'b0, 1'b0, "R4 inv-a");
    for (int k = 0; k < e; k++) ilv[k] = cap[k];
    run_seq(e, q, 1'b1, 1'b0, "R4 inv-b");
    for (int p = 0; p < e; p++)
      chk(ilv[cap[p]] == p, "R4 round trip", ilv[cap[p]], p);
    chk(c * q == e, "R4 shape", c * q, e);
  endtask

  task automatic t_degenerate();
    run_seq(7, 1, 1'b0, 1'b0, "R9 qm1 il");
    for (int k = 0; k < 7; k++) chk(cap[k] == k, "R9 identity qm1", cap[k], k);
    run_seq(7, 1, 1'b1, 1'b0, "R9 qm1 de");
    run_seq(8, 8, 1'b0, 1'b0, "R9 one column il");
    for (int k = 0; k < 8; k++) chk(cap[k] == k, "R9 identity one column", cap[k], k);
    run_seq(6, 6, 1'b1, 1'b0, "R9 one column de");
  endtask

  initial begin
    t_reset();
    run_seq(20, 4, 1'b0, 1'b0, "R3 E20 Q4");
    chk(cap[1] == 5 && cap[3] == 15, "R3 stride 5", cap[1], 5);
    run_seq(24, 6, 1'b0, 1'b0, "R3 E24 Q6");
    run_seq(16, 2, 1'b0, 1'b0, "R3 E16 Q2");
    run_seq(20, 4, 1'b1, 1'b0, "R4 E20 Q4");
    run_seq(48, 8, 1'b1, 1'b0, "R4 E48 Q8");
    run_seq(1016, 8, 1'b0, 1'b0, "R3 E1016 Q8");
    run_seq(40, 4, 1'b0, 1'b1, "R7 poke il");
    run_seq(36, 6, 1'b1, 1'b1, "R7 poke de");
    t_illegal();
    run_seq(12, 2, 1'b0, 1'b0, "R8 back-to-back a");
    run_seq(30, 6, 1'b1, 1'b0, "R8 back-to-back b");
    t_inverse(96, 6);
    t_degenerate();
    finish_up();
  end
endmodule